// File: doc/BRIEF.md
# Per-Queue Selectable Interrupt Generator

This block turns the status flags of 64 hardware queues into two interrupt lines: one serves queues 0 to 31 (the lower half) and one serves queues 32 to 63 (the upper half). The queue storage lives elsewhere. Its flags arrive on input ports. A lower queue provides four flags. An upper queue provides only its nearly-empty flag.

Each lower queue has a 3-bit source select. Two of its bits choose which of the four flags is tested, and the third inverts the result. Every upper queue uses one fixed condition: the queue is not nearly empty. When a queue's condition goes from false to true, the block latches a pending bit. Software clears a pending bit by writing 1 to it. A per-half enable register masks the pending bits before they drive the interrupt line. Clearing an enable bit also clears the pending bit of that queue.

Software uses a small register port. Writes take one clock. Reads are combinational from the address. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `qirq_gen`

## Requirements
- R1: While reset is asserted, and after it is released, all source selects, enable bits and pending bits read 0, and both interrupt outputs are low.
- R2: Addresses 0 to 3 hold the source selects. Queue i sits in the register at address i/8, at bits (i mod 8)*4+2 down to (i mod 8)*4. Bit (i mod 8)*4+3 is reserved and always reads 0.
- R3: For a lower queue, select bits 1:0 pick a bit of that queue's 4-bit flag field: 0 is empty, 1 is nearly empty, 2 is nearly full and 3 is full. Select bit 2 set inverts the tested flag.
- R4: The condition of an upper queue is the inverse of its nearly-empty input bit. No register changes it.
- R5: A pending bit is set only on a false-to-true change of its queue's condition. A condition that stays true does not set the bit again after it has been cleared, and a true-to-false change does not set it.
- R6: Writing 1 to a bit at address 4 (lower pending) or address 5 (upper pending) clears that bit. Writing 0 to a bit leaves it unchanged.
- R7: When a set and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R8: Address 6 (lower enable) and address 7 (upper enable) are read/write. A write that changes an enable bit from 1 to 0 also clears that queue's pending bit. A write-1-to-clear of a pending bit leaves the enable bits unchanged.
- R9: Each interrupt output is a register holding the OR of (pending AND enable) over its half. It rises one cycle after the enabled pending bit becomes readable.
- R10: A pending bit latches whether or not its enable bit is set. While that bit is disabled, the interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| lo_flags | input | 128 | Flags of lower queue i at bits 4i+3:4i (full, nearly full, nearly empty, empty) |
| hi_near_empty | input | 32 | Nearly-empty flag of upper queue 32+j at bit j |
| irq_lo | output | 1 | Interrupt line for queues 0 to 31 |
| irq_hi | output | 1 | Interrupt line for queues 32 to 63 |

## Verification
The embedded properties run on every cycle and check the pending-bit rules:
- a bit never rises without a condition edge;
- an edge always sets its bit, even against a clear;
- bits hold when no register is written;
- a disabling write leaves the affected bits clear;
- a masked half never drives its line.

Some behaviour is visible only through the bench's scenarios:
- the mapping of flags to conditions through the select field and the inversion bit;
- the fixed condition of the upper queues;
- the positions and reserved bits of the select fields;
- the one-cycle latency from pending to interrupt.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int SEL_W   = 3;
  localparam int FIELD_W = 4;
  localparam int FLAG_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_SEL0    = 3'd0,
    A_SEL1    = 3'd1,
    A_SEL2    = 3'd2,
    A_SEL3    = 3'd3,
    A_PEND_LO = 3'd4,
    A_PEND_HI = 3'd5,
    A_EN_LO   = 3'd6,
    A_EN_HI   = 3'd7
  } qirq_addr_e;
endpackage

// File: rtl/qirq_src_regs.sv
module qirq_src_regs
  import qirq_pkg::*;
#(
  parameter int HALF = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [HALF/(REG_W/FIELD_W)-1:0] wr_vec,
  input  logic [REG_W-1:0]          wdata,
  output logic [HALF*SEL_W-1:0]     sel_flat,
  output logic [HALF*FIELD_W-1:0]   rd_flat
);
  localparam int QPR = REG_W / FIELD_W;

  logic [REG_W-1:0] rsvd_mask;
  logic             unused_rsvd;

  always_comb begin
    rsvd_mask = '0;
    for (int k = 0; k < QPR; k++) rsvd_mask[k*FIELD_W + FIELD_W-1] = 1'b1;
  end
  assign unused_rsvd = ^(wdata & rsvd_mask);

  for (genvar g = 0; g < HALF; g++) begin : g_sel
    logic [SEL_W-1:0] sel_d;
    logic [SEL_W-1:0] sel_q;

    always_comb begin
      sel_d = sel_q;
      if (wr_vec[g/QPR]) sel_d = wdata[(g%QPR)*FIELD_W +: SEL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_d;
    end

    assign sel_flat[g*SEL_W +: SEL_W]     = sel_q;
    assign rd_flat[g*FIELD_W +: FIELD_W]  = {1'b0, sel_q};
  end
endmodule

// File: rtl/qirq_cond.sv
module qirq_cond
  import qirq_pkg::*;
#(
  parameter int HALF = 32
) (
  input  logic [HALF*FLAG_W-1:0] lo_flags,
  input  logic [HALF-1:0]        hi_near_empty,
  input  logic [HALF*SEL_W-1:0]  sel_flat,
  output logic [HALF-1:0]        cond_lo,
  output logic [HALF-1:0]        cond_hi
);
  for (genvar g = 0; g < HALF; g++) begin : g_lo
    logic [FLAG_W-1:0] flags;
    logic [SEL_W-1:0]  sel;
    assign flags      = lo_flags[g*FLAG_W +: FLAG_W];
    assign sel        = sel_flat[g*SEL_W +: SEL_W];
    assign cond_lo[g] = flags[sel[1:0]] ^ sel[2];
  end

  assign cond_hi = ~hi_near_empty;
endmodule

// File: rtl/qirq_half.sv
module qirq_half #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         pend_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] en_q,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] clr;
  logic [W-1:0] pend_d;
  logic [W-1:0] en_d;
  logic         irq_d;

  always_comb begin
    rise   = cond & ~prev_q;
    clr    = '0;
    if (pend_wr) clr = clr | wdata;
    if (en_wr)   clr = clr | (en_q & ~wdata);
    pend_d = rise | (pend_q & ~clr);
    en_d   = en_wr ? wdata : en_q;
    irq_d  = |(pend_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= cond;
      pend_q <= pend_d;
      en_q   <= en_d;
      irq    <= irq_d;
    end
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise))); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && ((rise & wdata) != '0)) |=> ((pend_q & $past(rise & wdata)) == $past(rise & wdata))); // R7
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0)); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && !en_wr) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((pend_q & $past(en_q & ~wdata & ~rise)) == '0)); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & en_q) == '0) |=> !irq); // R10
endmodule

// File: rtl/qirq_gen.sv
module qirq_gen
  import qirq_pkg::*;
#(
  parameter int NUM_Q = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  input  logic [NUM_Q/2*FLAG_W-1:0] lo_flags,
  input  logic [NUM_Q/2-1:0]       hi_near_empty,
  output logic                     irq_lo,
  output logic                     irq_hi
);
  localparam int HALF = NUM_Q / 2;
  localparam int QPR  = REG_W / FIELD_W;
  localparam int NSEL = HALF / QPR;

  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  qirq_addr_e                addr;
  logic [NSEL-1:0]           sel_wr;
  logic [HALF*SEL_W-1:0]     sel_flat;
  logic [HALF*FIELD_W-1:0]   sel_rd;
  logic [HALF-1:0]           cond_lo;
  logic [HALF-1:0]           cond_hi;
  logic [1:0]                pend_wr;
  logic [1:0]                en_wr;
  logic [HALF-1:0]           pend_q [2];
  logic [HALF-1:0]           en_q   [2];
  logic [1:0]                irq_v;

  assign addr = qirq_addr_e'(reg_addr);

  always_comb begin
    for (int i = 0; i < NSEL; i++) sel_wr[i] = reg_wr && (reg_addr == ADDR_W'(i));
    pend_wr[0] = reg_wr && (addr == A_PEND_LO);
    pend_wr[1] = reg_wr && (addr == A_PEND_HI);
    en_wr[0]   = reg_wr && (addr == A_EN_LO);
    en_wr[1]   = reg_wr && (addr == A_EN_HI);
  end

  qirq_src_regs #(.HALF(HALF)) i_src (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_vec   (sel_wr),
    .wdata    (reg_wdata),
    .sel_flat (sel_flat),
    .rd_flat  (sel_rd)
  );

  qirq_cond #(.HALF(HALF)) i_cond (
    .lo_flags      (lo_flags),
    .hi_near_empty (hi_near_empty),
    .sel_flat      (sel_flat),
    .cond_lo       (cond_lo),
    .cond_hi       (cond_hi)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    qirq_half #(.W(HALF)) i_half (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .cond    ((h == 0) ? cond_lo : cond_hi),
      .pend_wr (pend_wr[h]),
      .en_wr   (en_wr[h]),
      .wdata   (reg_wdata[HALF-1:0]),
      .pend_q  (pend_q[h]),
      .en_q    (en_q[h]),
      .irq     (irq_v[h])
    );
  end

  assign irq_lo = irq_v[0];
  assign irq_hi = irq_v[1];

  always_comb begin
    reg_rdata = '0;
    case (addr)
      A_PEND_LO: reg_rdata = REG_W'(pend_q[0]);
      A_PEND_HI: reg_rdata = REG_W'(pend_q[1]);
      A_EN_LO:   reg_rdata = REG_W'(en_q[0]);
      A_EN_HI:   reg_rdata = REG_W'(en_q[1]);
      default:   reg_rdata = sel_rd[reg_addr[1:0]*REG_W +: REG_W];
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq_lo && !irq_hi)); // R1
endmodule

// File: tb/test_qirq_gen.sv
module test_qirq_gen;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [127:0] lo_flags;
  logic [31:0]  hi_near_empty;
  logic         irq_lo;
  logic         irq_hi;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  qirq_gen i_qirq_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .lo_flags      (lo_flags),
    .hi_near_empty (hi_near_empty),
    .irq_lo        (irq_lo),
    .irq_hi        (irq_hi)
  );

  // {write, addr, data}; for a read row the data is the expected value
  localparam logic [35:0] VEC [10] = '{
    {1'b1, 3'd0, 32'hFFFF_FFFF},
    {1'b0, 3'd0, 32'h7777_7777},
    {1'b1, 3'd3, 32'h1234_5678},
    {1'b0, 3'd3, 32'h1234_5670},
    {1'b0, 3'd1, 32'h0000_0000},
    {1'b1, 3'd0, 32'h0000_0000},
    {1'b1, 3'd3, 32'h0000_0000},
    {1'b0, 3'd0, 32'h0000_0000},
    {1'b1, 3'd4, 32'hFFFF_FFFF},
    {1'b0, 3'd4, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    lo_flags = '0; hi_near_empty = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: state after reset
    rd_chk("R1 sel0", 3'd0, 32'h0);
    rd_chk("R1 pend_lo", 3'd4, 32'h0);
    rd_chk("R1 pend_hi", 3'd5, 32'h0);
    rd_chk("R1 en_lo", 3'd6, 32'h0);
    rd_chk("R1 en_hi", 3'd7, 32'h0);
    check("R1 irq", {30'd0, irq_hi, irq_lo}, 32'h0);

    // R2 / R6: vector table on select field layout and clear of pending
    for (int v = 0; v < 10; v++) begin
      if (VEC[v][35]) wr_reg(VEC[v][34:32], VEC[v][31:0]);
      else begin
        @(negedge clk);
        rd_chk($sformatf("R2 vec%0d", v), VEC[v][34:32], VEC[v][31:0]);
      end
    end

    // R3: queue 5 tests nearly full (select 2)
    wr_reg(3'd0, 32'h0020_0000);
    @(negedge clk);
    lo_flags[5*4+2] = 1'b1;
    @(negedge clk);
    rd_chk("R3 nearly-full selected", 3'd4, 32'h0000_0020);
    wr_reg(3'd4, 32'h0000_0020);
    rd_chk("R6 w1c", 3'd4, 32'h0);

    // R3: queue 9 tests inverted full (select 7)
    lo_flags[9*4+3] = 1'b1;
    wr_reg(3'd1, 32'h0000_0070);
    @(negedge clk);
    rd_chk("R3 inverted idle", 3'd4, 32'h0);
    lo_flags[9*4+3] = 1'b0;
    @(negedge clk);
    rd_chk("R3 inverted full", 3'd4, 32'h0000_0200);

    // R4: upper queue 40 raises on not nearly empty
    hi_near_empty[8] = 1'b0;
    @(negedge clk);
    rd_chk("R4 upper pend", 3'd5, 32'h0000_0100);
    rd_chk("R4 lower unchanged", 3'd4, 32'h0000_0200);

    // R5: steady true does not re-set; falling edge does not set
    wr_reg(3'd5, 32'h0000_0100);
    repeat (3) @(negedge clk);
    rd_chk("R5 steady true", 3'd5, 32'h0);
    hi_near_empty[8] = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R5 falling", 3'd5, 32'h0);

    // R6: writing zeros has no effect
    wr_reg(3'd4, 32'h0);
    rd_chk("R6 zero write", 3'd4, 32'h0000_0200);

    // R7: set and clear in the same cycle
    @(negedge clk);
    hi_near_empty[8] = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h0000_0100;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_chk("R7 set wins", 3'd5, 32'h0000_0100);

    // R10 / R9: latched while disabled, then enabled
    check("R10 masked irq_hi", {31'd0, irq_hi}, 32'h0);
    wr_reg(3'd7, 32'h0000_0100);
    check("R9 irq latency", {31'd0, irq_hi}, 32'h0);
    @(negedge clk);
    check("R9 irq_hi high", {31'd0, irq_hi}, 32'h1);
    check("R9 irq_lo low", {31'd0, irq_lo}, 32'h0);

    // R8: disabling clears pending
    wr_reg(3'd7, 32'h0);
    rd_chk("R8 pend cleared", 3'd5, 32'h0);
    rd_chk("R8 en cleared", 3'd7, 32'h0);
    @(negedge clk);
    check("R9 irq_hi drops", {31'd0, irq_hi}, 32'h0);

    // R9: lower half line
    wr_reg(3'd6, 32'h0000_0200);
    @(negedge clk);
    check("R9 irq_lo high", {31'd0, irq_lo}, 32'h1);
    wr_reg(3'd4, 32'h0000_0200);
    @(negedge clk);
    check("R9 irq_lo after clear", {31'd0, irq_lo}, 32'h0);
    rd_chk("R8 enable kept", 3'd6, 32'h0000_0200);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    rd_chk("R1 midrun en_lo", 3'd6, 32'h0);
    rd_chk("R1 midrun sel1", 3'd1, 32'h0);
    rd_chk("R1 midrun pend_lo", 3'd4, 32'h0);
    check("R1 midrun irq", {30'd0, irq_hi, irq_lo}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule